// File: doc/BRIEF.md
# Block-Scaled FP4 Dequantizer

This block unpacks one microscaled block of 4-bit floating point data into single-precision numbers. A block is a 136-bit word: 32 elements in the E2M1 layout (sign, two exponent bits, one mantissa bit) and one shared 8-bit scale. The scale has no sign and no mantissa, and it stands for a power of two. The block is taken in through a valid/ready handshake. The 32 decoded values then leave one per cycle, in index order, as IEEE-754 single-precision words, each with its element index and a last flag.

No multiplier is used for the scaling. Each element is first turned into a sign, an unbiased exponent and one mantissa bit. The shared scale code is then added to that exponent, which gives the single-precision biased exponent directly. The result is clamped at both ends of the range: below the normal range it flushes to a signed zero, and above it the result becomes a signed infinity. A scale holding the reserved NaN code turns the whole block into NaN.

The block sits between a memory stream of packed low-precision tensors and an FP32 datapath. It holds one block at a time and accepts the next only after the final element of the current block has been consumed.

Top module: `bsfp4_unpack`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A block is captured only in a cycle where in_valid and in_ready are both 1. in_ready stays 0 while a block is being emitted, and a block offered during that time has no effect on the values emitted.
- R3: The 32 elements leave in index order 0 to 31. Element i is taken from in_block bits [4i+3:4i] and the scale from bits [135:128]. out_index carries i, and out_last is 1 only with index 31.
- R4: While out_valid is 1 and out_ready is 0, out_data, out_index and out_last stay unchanged.
- R5: With a non-NaN scale, an element whose magnitude code (bits [2:0]) is 0 yields a zero with the element's sign, for every scale.
- R6: A scale code of 0xFF makes all 32 outputs equal to 0x7FC00000.
- R7: Magnitude codes 2 to 7 stand for 1, 1.5, 2, 3, 4 and 6. Each output equals that value times 2^(scale-127), encoded exactly in single precision.
- R8: Magnitude code 1 is the subnormal 0.5, and its output is 2^(scale-128).
- R9: If the rescaled single-precision biased exponent would be 0 or below, the output is a zero with the element's sign.
- R10: If the rescaled biased exponent would be 255 or above, the output is an infinity with the element's sign (exponent 0xFF, fraction 0).
- R11: For every non-NaN scale, out_data bit 31 equals the element's bit 3.
- R12: in_ready returns to 1 in the cycle after the handshake that carries out_last. The next block can be captured at the clock edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packed block on in_block is valid |
| in_ready | output | 1 | Block can be captured this cycle |
| in_block | input | 136 | Scale in [135:128], element i in [4i+3:4i] |
| out_valid | output | 1 | out_data carries a decoded element |
| out_ready | input | 1 | Consumer takes the element this cycle |
| out_data | output | 32 | Decoded single-precision value |
| out_index | output | 5 | Index of the element on out_data |
| out_last | output | 1 | Marks element 31 of the block |

## Verification
Two events can fall in the same cycle. The handshake that completes a block can coincide with a new block that is already waiting on in_valid. A consumer stall can also coincide with an element whose rescaled exponent lies exactly on the underflow or overflow limit. The bench provokes both at once: it holds in_valid high with a different block for the whole time a block is being emitted, and it withholds out_ready at random. It then checks three things. Every emitted value must still match the first block. No capture may happen at the final handshake. in_ready must rise only in the following cycle. Directed scales of 0, 253, 254 and 0xFF place elements on both sides of the limits, and stalls fall on those elements as well.

// File: rtl/bsfp4_pkg.sv
package bsfp4_pkg;

    localparam int E2M1_W      = 4;
    localparam int E8M0_W      = 8;
    localparam int FP32_W      = 32;
    localparam int FP32_EXP_W  = 8;
    localparam int FP32_FRAC_W = 23;

    localparam logic [E8M0_W-1:0] SCALE_NAN_CODE = 8'hFF;
    localparam logic [FP32_W-1:0] FP32_QNAN      = 32'h7FC0_0000;
    localparam logic [FP32_EXP_W-1:0] FP32_EXP_MAX = 8'hFF;

    // Decoded E2M1 element: value = (1 + mant/2) * 2^unb_exp, or zero
    typedef struct packed {
        logic              sign;
        logic              zero;
        logic signed [2:0] unb_exp;
        logic              mant;
    } e2m1_dec_t;

endpackage

// File: rtl/bsfp4_elem_pick.sv
module bsfp4_elem_pick
    import bsfp4_pkg::*;
#(
    parameter int ELEM_COUNT = 32,
    localparam int IDX_W     = $clog2(ELEM_COUNT),
    localparam int FIELD_W   = ELEM_COUNT * E2M1_W
) (
    input  logic [FIELD_W-1:0] field_i,
    input  logic [IDX_W-1:0]   sel_i,
    output logic [E2M1_W-1:0]  elem_o
);

    logic [E2M1_W-1:0] lanes [ELEM_COUNT];

    for (genvar g = 0; g < ELEM_COUNT; g++) begin : g_lane
        assign lanes[g] = field_i[g*E2M1_W +: E2M1_W];
    end

    assign elem_o = lanes[sel_i];

endmodule

// File: rtl/bsfp4_e2m1_decode.sv
module bsfp4_e2m1_decode
    import bsfp4_pkg::*;
(
    input  logic [E2M1_W-1:0] code_i,
    output e2m1_dec_t         dec_o
);

    logic [1:0] exp_field;
    logic       mant_field;

    assign exp_field  = code_i[2:1];
    assign mant_field = code_i[0];

    always_comb begin
        dec_o.sign = code_i[3];
        dec_o.zero = (code_i[2:0] == 3'd0);
        if (exp_field == 2'd0) begin
            // subnormal 0.5 is 1.0 * 2^-1 once normalized
            dec_o.unb_exp = -3'sd1;
            dec_o.mant    = 1'b0;
        end else begin
            dec_o.unb_exp = $signed({1'b0, exp_field}) - 3'sd1;
            dec_o.mant    = mant_field;
        end
    end

endmodule

// File: rtl/bsfp4_rescale.sv
module bsfp4_rescale
    import bsfp4_pkg::*;
(
    input  logic [E8M0_W-1:0] scale_i,
    input  e2m1_dec_t         dec_i,
    output logic [FP32_W-1:0] fp_o
);

    localparam int SUM_W = E8M0_W + 2;

    logic signed [SUM_W-1:0] biased;
    logic                    scale_nan;
    logic                    underflow;
    logic                    overflow;

    // scale code already carries the +127 bias that FP32 needs
    assign biased    = $signed({2'b00, scale_i})
                     + $signed({{(SUM_W-3){dec_i.unb_exp[2]}}, dec_i.unb_exp});
    assign scale_nan = (scale_i == SCALE_NAN_CODE);
    assign underflow = (biased <= $signed(SUM_W'(0)));
    assign overflow  = (biased >= $signed(SUM_W'(255)));

    always_comb begin
        if (scale_nan) begin
            fp_o = FP32_QNAN;
        end else if (dec_i.zero || underflow) begin
            fp_o = {dec_i.sign, {(FP32_W-1){1'b0}}};
        end else if (overflow) begin
            fp_o = {dec_i.sign, FP32_EXP_MAX, {FP32_FRAC_W{1'b0}}};
        end else begin
            fp_o = {dec_i.sign, biased[FP32_EXP_W-1:0], dec_i.mant,
                    {(FP32_FRAC_W-1){1'b0}}};
        end
    end

endmodule

// File: rtl/bsfp4_unpack.sv
module bsfp4_unpack
    import bsfp4_pkg::*;
#(
    parameter int ELEM_COUNT = 32,
    localparam int IDX_W     = $clog2(ELEM_COUNT),
    localparam int FIELD_W   = ELEM_COUNT * E2M1_W,
    localparam int BLOCK_W   = FIELD_W + E8M0_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BLOCK_W-1:0] in_block,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [FP32_W-1:0]  out_data,
    output logic [IDX_W-1:0]   out_index,
    output logic               out_last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ELEM_COUNT - 1);

    typedef struct packed {
        logic               busy;
        logic [IDX_W-1:0]   idx;
        logic [E8M0_W-1:0]  scale;
        logic [FIELD_W-1:0] elems;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [E2M1_W-1:0] cur_code;
    e2m1_dec_t         cur_dec;
    logic              at_last;

    assign at_last = (st_q.idx == LAST_IDX);

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (in_valid) begin
                st_d.busy  = 1'b1;
                st_d.idx   = '0;
                st_d.scale = in_block[BLOCK_W-1 -: E8M0_W];
                st_d.elems = in_block[FIELD_W-1:0];
            end
        end else if (out_ready) begin
            if (at_last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    bsfp4_elem_pick #(
        .ELEM_COUNT (ELEM_COUNT)
    ) u_pick (
        .field_i (st_q.elems),
        .sel_i   (st_q.idx),
        .elem_o  (cur_code)
    );

    bsfp4_e2m1_decode u_dec (
        .code_i (cur_code),
        .dec_o  (cur_dec)
    );

    bsfp4_rescale u_scale (
        .scale_i (st_q.scale),
        .dec_i   (cur_dec),
        .fp_o    (out_data)
    );

    assign in_ready  = !st_q.busy;
    assign out_valid = st_q.busy;
    assign out_index = st_q.idx;
    assign out_last  = st_q.busy && at_last;

endmodule

// File: rtl/bsfp4_unpack_chk.sv
module bsfp4_unpack_chk
    import bsfp4_pkg::*;
#(
    parameter int ELEM_COUNT = 32,
    localparam int IDX_W     = $clog2(ELEM_COUNT),
    localparam int FIELD_W   = ELEM_COUNT * E2M1_W,
    localparam int BLOCK_W   = FIELD_W + E8M0_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [BLOCK_W-1:0] in_block,
    input logic               out_valid,
    input logic               out_ready,
    input logic [FP32_W-1:0]  out_data,
    input logic [IDX_W-1:0]   out_index,
    input logic               out_last
);

    logic [E8M0_W-1:0]  scale_cap;
    logic [FIELD_W-1:0] elems_cap;
    logic [E2M1_W-1:0]  cur_elem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scale_cap <= '0;
            elems_cap <= '0;
        end else if (in_valid && in_ready) begin
            scale_cap <= in_block[BLOCK_W-1 -: E8M0_W];
            elems_cap <= in_block[FIELD_W-1:0];
        end
    end

    assign cur_elem = elems_cap[32'(out_index)*E2M1_W +: E2M1_W];

    // R2: a capture starts the stream at element 0
    a_r2_capture_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_index == '0 && !in_ready));

    // R3: each accepted non-final element is followed by the next index
    a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=>
            (out_valid && out_index == $past(out_index) + 1'b1));

    // R12: final handshake frees the input side in the next cycle
    a_r12_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

    // R4: a stalled element holds still
    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_index) && $stable(out_last)));

    // R6: reserved scale code poisons every element
    a_r6_nan_scale: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && scale_cap == SCALE_NAN_CODE) |-> (out_data == FP32_QNAN));

    // R5: zero elements stay signed zero
    a_r5_zero_elem: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && scale_cap != SCALE_NAN_CODE && cur_elem[2:0] == 3'd0) |->
            (out_data == {cur_elem[3], 31'd0}));

    // R11: sign follows the element
    a_r11_sign_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && scale_cap != SCALE_NAN_CODE) |-> (out_data[31] == cur_elem[3]));

    // R10: a non-NaN scale never yields a NaN pattern
    a_r10_no_nan_from_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && scale_cap != SCALE_NAN_CODE && out_data[30:23] == FP32_EXP_MAX) |->
            (out_data[22:0] == 23'd0));

endmodule

bind bsfp4_unpack bsfp4_unpack_chk #(.ELEM_COUNT(ELEM_COUNT)) u_chk (.*);

// File: tb/bsfp4_unpack_tb.sv
module bsfp4_unpack_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [135:0] in_block = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [31:0]  out_data;
    logic [4:0]   out_index;
    logic         out_last;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;   // 50 MHz

    bsfp4_unpack u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_block  (in_block),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_index (out_index),
        .out_last  (out_last)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected value from the requirements: magnitude in half-units
    function automatic logic [31:0] ref_fp(input logic [7:0] sc, input logic [3:0] e);
        int h, fl, b;
        logic m;
        if (sc == 8'hFF) return 32'h7FC0_0000;
        case (e[2:0])
            3'd0: h = 0;  3'd1: h = 1;  3'd2: h = 2;  3'd3: h = 3;
            3'd4: h = 4;  3'd5: h = 6;  3'd6: h = 8;  default: h = 12;
        endcase
        if (h == 0) return {e[3], 31'd0};
        fl = (h >= 8) ? 3 : (h >= 4) ? 2 : (h >= 2) ? 1 : 0;
        m  = (h == 3 || h == 6 || h == 12);
        b  = int'(sc) + fl - 1;
        if (b <= 0)   return {e[3], 31'd0};
        if (b >= 255) return {e[3], 8'hFF, 23'd0};
        return {e[3], b[7:0], m, 22'd0};
    endfunction

    function automatic string req_of(input logic [7:0] sc, input logic [3:0] e);
        int b;
        if (sc == 8'hFF) return "R6";
        if (e[2:0] == 3'd0) return "R5";
        b = int'(sc) + ((e[2:1] == 2'd0) ? -1 : int'(e[2:1]) - 1);
        if (b <= 0) return "R9";
        if (b >= 255) return "R10";
        if (e[2:0] == 3'd1) return "R8";
        return "R7";
    endfunction

    task automatic run_block(input logic [135:0] blk, input int stall_pct);
        int got = 0;
        logic [31:0] exp_v;
        logic [3:0]  el;
        logic        rdy;
        @(negedge clk);
        in_block = blk;
        in_valid = 1'b1;
        check(in_ready == 1'b1, "R12 in_ready before capture", 64'(in_ready), 64'd1);
        @(negedge clk);
        // R2: offer a conflicting block for the whole emission
        in_block = ~blk;
        check(in_ready == 1'b0, "R2 in_ready low while busy", 64'(in_ready), 64'd0);
        while (got < 32) begin
            rdy = (($urandom % 100) >= stall_pct);
            out_ready = rdy;
            el    = blk[got*4 +: 4];
            exp_v = ref_fp(blk[135:128], el);
            check(out_valid && out_index == 5'(got) && out_last == (got == 31),
                  "R3 order/index/last", {out_valid, out_last, 57'(out_index)},
                  {1'b1, got == 31, 57'(got)});
            check(out_data == exp_v, req_of(blk[135:128], el), 64'(out_data), 64'(exp_v));
            if (blk[135:128] != 8'hFF)
                check(out_data[31] == el[3], "R11 sign", 64'(out_data[31]), 64'(el[3]));
            check(in_ready == 1'b0, "R2 busy", 64'(in_ready), 64'd0);
            @(negedge clk);
            if (rdy) begin
                got++;
            end else begin
                check(out_data == exp_v && out_index == 5'(got), "R4 hold on stall",
                      {27'd0, out_index, out_data}, {27'd0, 5'(got), exp_v});
            end
        end
        in_valid  = 1'b0;
        out_ready = 1'b0;
        check(!out_valid && in_ready, "R12 ready after last", {out_valid, in_ready},
              64'b01);
    endtask

    function automatic logic [135:0] mk_block(input logic [7:0] sc, input int pat);
        logic [135:0] b;
        b[135:128] = sc;
        for (int i = 0; i < 32; i++) begin
            b[i*4 +: 4] = (pat == 0) ? 4'(i) : 4'($urandom);
        end
        return b;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!out_valid && in_ready, "R1 reset state", {out_valid, in_ready}, 64'b01);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R1 idle after reset", {out_valid, in_ready}, 64'b01);
        // R7, R8, R5: unit scale, all sixteen codes twice
        run_block(mk_block(8'd127, 0), 0);
        // R6: reserved scale
        run_block(mk_block(8'hFF, 0), 25);
        // R9: underflow boundary
        run_block(mk_block(8'd0, 0), 40);
        run_block(mk_block(8'd1, 0), 20);
        // R10: overflow boundary
        run_block(mk_block(8'd254, 0), 40);
        run_block(mk_block(8'd253, 0), 20);
        for (int k = 0; k < 8; k++) begin
            run_block(mk_block(8'($urandom), 1), 30);
        end
        run_block(mk_block(8'd2, 1), 50);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule